// File: doc/BRIEF.md
# Rename History Buffer with Rollback

This block keeps an ordered record of destination-register renames for one thread of an out-of-order core. Every renamed destination operand pushes one entry at the young end. Each entry holds the instruction sequence number, the architectural register, the freshly allocated physical register and the physical register it displaced. The record lets the core undo speculative mappings after a squash and recycle superseded physical registers once their owners retire.

A squash request starts a walk from the young end. Each removed entry produces a map-table write that puts the displaced register back, and a free-list return of the newly allocated register. A returned register whose index falls in the miscellaneous range, at or above the integer-plus-float count, is also reported to the scoreboard as ready. A commit request starts a walk from the old end. Each removed entry returns the displaced register to the free list and leaves the map alone. Either walk removes at most one entry per clock. The map table, the free list and the scoreboard live outside the block.

Top module: `rename_hist_buf`

## Requirements
- R1: While reset is asserted and after it is released, `empty` is 1, while `full`, `busy`, `map_wr_vld`, `free_vld` and `ready_vld` are 0.
- R2: A push is stored at the young end. `full` rises when DEPTH entries are held, and a push offered while `full` is 1 is dropped.
- R3: After a squash request, from the next cycle on, one entry per cycle is removed from the young end while its sequence number is greater than the squash bound. Each removal drives `map_wr_vld` with the entry's architectural register and displaced register, and drives `free_vld` with its new register.
- R4: A squash removal whose new register index is at least INT_PREGS+FP_PREGS also drives `ready_vld` with that same register. Other removals leave `ready_vld` at 0.
- R5: After a commit request, from the next cycle on, one entry per cycle is removed from the old end while its sequence number is at most the commit bound. Each removal drives `free_vld` with the displaced register, while `map_wr_vld` and `ready_vld` stay 0.
- R6: A commit on an empty buffer, or on one whose oldest entry has a sequence number above the bound, removes nothing and drives no strobe.
- R7: A commit request in the same cycle as a squash request, or during a squash walk, is dropped. A squash request stops a commit walk, and in the cycle of a squash request no entry is removed.
- R8: `busy` is 1 from the cycle after a request until the first cycle in which the walk finds nothing left to remove, so a walk that removes N entries shows `busy` for N+1 cycles.
- R9: A squash on an empty buffer removes nothing and holds `busy` for one cycle.
- R10: Pushes are dropped in a squash-request cycle and during a squash walk. During a commit walk they are accepted.
- R11: A commit request that arrives during a commit walk replaces the walk's bound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_vld | input | 1 | Record one destination rename |
| push_seq | input | SEQW | Sequence number of the renaming instruction |
| push_arch | input | ARCHW | Architectural destination register |
| push_new | input | PREGW | Newly allocated physical register |
| push_prev | input | PREGW | Physical register previously mapped |
| squash_vld | input | 1 | Start a rollback walk |
| squash_seq | input | SEQW | Entries with a larger sequence number are undone |
| commit_vld | input | 1 | Start a retire walk |
| commit_seq | input | SEQW | Entries at or below this sequence number retire |
| full | output | 1 | DEPTH entries held; pushes are dropped |
| empty | output | 1 | No entries held |
| busy | output | 1 | A walk is in progress |
| map_wr_vld | output | 1 | Map-table restore strobe |
| map_wr_arch | output | ARCHW | Architectural register to restore |
| map_wr_preg | output | PREGW | Physical register to write back into the map |
| free_vld | output | 1 | Free-list return strobe |
| free_preg | output | PREGW | Physical register returned |
| ready_vld | output | 1 | Scoreboard set-ready strobe |
| ready_preg | output | PREGW | Physical register marked ready |

## Verification
The collisions that matter are a squash against a commit, and a squash against a push. The bench raises squash and commit in the same cycle, then raises squash one cycle into a running commit walk while commit stays asserted through the rollback. It then checks that the strobe trace has exactly the one retirement that came before the squash, followed by the young-to-old undo. For push against squash, pushes are held through the request and the walk, and a final drain shows that none of them landed. A push during a commit walk is shown to land. Sweeps over every fill level and every squash and commit bound compare each strobe against values computed from the entry numbering.

// File: rtl/rhb_pkg.sv
package rhb_pkg;
  typedef enum logic [1:0] {
    WALK_IDLE   = 2'd0,
    WALK_UNDO   = 2'd1,
    WALK_RETIRE = 2'd2
  } walk_e;
endpackage

// File: rtl/rhb_store.sv
module rhb_store #(
  parameter int DEPTH = 8,
  parameter int ENTW  = 24,
  parameter int OLDW  = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_en,
  input  logic [ENTW-1:0] push_data,
  input  logic            pop_old,
  input  logic            pop_young,
  output logic [OLDW-1:0] old_data,
  output logic [ENTW-1:0] young_data,
  output logic            empty,
  output logic            full
);
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam logic [PTRW-1:0] LAST = PTRW'(DEPTH - 1);

  logic [PTRW-1:0] head_q, head_d, tail_q, tail_d, young_idx;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic [ENTW-1:0] slot_q [DEPTH];

  function automatic logic [PTRW-1:0] ptr_inc(input logic [PTRW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PTRW-1:0] ptr_dec(input logic [PTRW-1:0] p);
    return (p == '0) ? LAST : p - 1'b1;
  endfunction

  always_comb begin
    young_idx = ptr_dec(tail_q);
    head_d    = pop_old ? ptr_inc(head_q) : head_q;
    if (push_en)        tail_d = ptr_inc(tail_q);
    else if (pop_young) tail_d = young_idx;
    else                tail_d = tail_q;
    cnt_d = cnt_q + CNTW'(push_en) - CNTW'(pop_old) - CNTW'(pop_young);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic wr_en;
    assign wr_en = push_en && (tail_q == PTRW'(i));
    always_ff @(posedge clk) begin
      if (wr_en) slot_q[i] <= push_data;
    end
  end

  assign old_data   = slot_q[head_q][OLDW-1:0];
  assign young_data = slot_q[young_idx];
  assign empty      = (cnt_q == '0);
  assign full       = (cnt_q == CNTW'(DEPTH));

  AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rst_n) full |-> !push_en); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) empty |-> !(pop_old || pop_young)); // R6
  AST_ONE_POP:      assert property (@(posedge clk) disable iff (!rst_n) !(pop_old && pop_young)); // R7
  AST_NO_PUSH_UNDO: assert property (@(posedge clk) disable iff (!rst_n) pop_young |-> !push_en); // R10
endmodule

// File: rtl/rhb_walk_ctrl.sv
module rhb_walk_ctrl
  import rhb_pkg::*;
#(
  parameter int SEQW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            squash_req,
  input  logic [SEQW-1:0] squash_seq,
  input  logic            commit_req,
  input  logic [SEQW-1:0] commit_seq,
  input  logic            empty,
  input  logic [SEQW-1:0] old_seq,
  input  logic [SEQW-1:0] young_seq,
  output logic            pop_old,
  output logic            pop_young,
  output logic            busy,
  output logic            undoing
);
  walk_e           mode_q, mode_d;
  logic [SEQW-1:0] bound_q, bound_d;

  always_comb begin
    pop_young = (mode_q == WALK_UNDO) && !squash_req && !empty && (young_seq > bound_q);
    pop_old   = (mode_q == WALK_RETIRE) && !squash_req && !empty && (old_seq <= bound_q);
    mode_d    = mode_q;
    bound_d   = bound_q;
    if (squash_req) begin
      mode_d  = WALK_UNDO;
      bound_d = squash_seq;
    end else if (mode_q == WALK_UNDO) begin
      if (!pop_young) mode_d = WALK_IDLE;
    end else if (commit_req) begin
      mode_d  = WALK_RETIRE;
      bound_d = commit_seq;
    end else if (mode_q == WALK_RETIRE) begin
      if (!pop_old) mode_d = WALK_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= WALK_IDLE;
      bound_q <= '0;
    end else begin
      mode_q  <= mode_d;
      bound_q <= bound_d;
    end
  end

  assign busy    = (mode_q != WALK_IDLE);
  assign undoing = (mode_q == WALK_UNDO);

  AST_REQ_MAKES_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (squash_req || commit_req) |=> busy); // R8
  AST_UNDO_ENDS:      assert property (@(posedge clk) disable iff (!rst_n) (undoing && !pop_young && !squash_req) |=> !busy); // R8
  AST_SQUASH_WINS:    assert property (@(posedge clk) disable iff (!rst_n) squash_req |=> undoing); // R7
endmodule

// File: rtl/rhb_release.sv
module rhb_release #(
  parameter int ARCHW     = 5,
  parameter int PREGW     = 6,
  parameter int MISC_BASE = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pop_young,
  input  logic [ARCHW-1:0] young_arch,
  input  logic [PREGW-1:0] young_new,
  input  logic [PREGW-1:0] young_prev,
  input  logic             pop_old,
  input  logic [PREGW-1:0] old_prev,
  output logic             map_wr_vld,
  output logic [ARCHW-1:0] map_wr_arch,
  output logic [PREGW-1:0] map_wr_preg,
  output logic             free_vld,
  output logic [PREGW-1:0] free_preg,
  output logic             ready_vld,
  output logic [PREGW-1:0] ready_preg
);
  logic is_misc;

  if (MISC_BASE >= (1 << PREGW)) begin : g_no_misc
    assign is_misc = 1'b0;
  end else begin : g_misc_cmp
    assign is_misc = (young_new >= PREGW'(MISC_BASE));
  end

  always_comb begin
    map_wr_vld  = pop_young;
    map_wr_arch = young_arch;
    map_wr_preg = young_prev;
    free_vld    = pop_young || pop_old;
    free_preg   = pop_young ? young_new : old_prev;
    ready_vld   = pop_young && is_misc;
    ready_preg  = young_new;
  end

  AST_READY_WITH_UNDO: assert property (@(posedge clk) disable iff (!rst_n) ready_vld |-> (free_vld && map_wr_vld)); // R4
  AST_READY_SAME_REG:  assert property (@(posedge clk) disable iff (!rst_n) ready_vld |-> (ready_preg == free_preg)); // R4
  AST_MAP_WITH_FREE:   assert property (@(posedge clk) disable iff (!rst_n) map_wr_vld |-> free_vld); // R3
endmodule

// File: rtl/rename_hist_buf.sv
module rename_hist_buf #(
  parameter int DEPTH      = 8,
  parameter int SEQW       = 8,
  parameter int ARCHW      = 5,
  parameter int INT_PREGS  = 24,
  parameter int FP_PREGS   = 24,
  parameter int MISC_PREGS = 8,
  localparam int MISC_BASE = INT_PREGS + FP_PREGS,
  localparam int PREGW     = $clog2(MISC_BASE + MISC_PREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_vld,
  input  logic [SEQW-1:0]  push_seq,
  input  logic [ARCHW-1:0] push_arch,
  input  logic [PREGW-1:0] push_new,
  input  logic [PREGW-1:0] push_prev,
  input  logic             squash_vld,
  input  logic [SEQW-1:0]  squash_seq,
  input  logic             commit_vld,
  input  logic [SEQW-1:0]  commit_seq,
  output logic             full,
  output logic             empty,
  output logic             busy,
  output logic             map_wr_vld,
  output logic [ARCHW-1:0] map_wr_arch,
  output logic [PREGW-1:0] map_wr_preg,
  output logic             free_vld,
  output logic [PREGW-1:0] free_preg,
  output logic             ready_vld,
  output logic [PREGW-1:0] ready_preg
);
  // Entry layout, low to high: prev, seq, new, arch. The old end reads only prev and seq.
  localparam int OLDW  = SEQW + PREGW;
  localparam int ENTW  = OLDW + PREGW + ARCHW;
  localparam int SEQ_LO  = PREGW;
  localparam int NEW_LO  = OLDW;
  localparam int ARCH_LO = OLDW + PREGW;

  logic            push_en, pop_old, pop_young, undoing;
  logic [ENTW-1:0] push_data, young_data;
  logic [OLDW-1:0] old_data;

  assign push_data = {push_arch, push_new, push_seq, push_prev};
  assign push_en   = push_vld && !full && !squash_vld && !undoing;

  rhb_store #(.DEPTH(DEPTH), .ENTW(ENTW), .OLDW(OLDW)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_en    (push_en),
    .push_data  (push_data),
    .pop_old    (pop_old),
    .pop_young  (pop_young),
    .old_data   (old_data),
    .young_data (young_data),
    .empty      (empty),
    .full       (full)
  );

  rhb_walk_ctrl #(.SEQW(SEQW)) u_walk (
    .clk        (clk),
    .rst_n      (rst_n),
    .squash_req (squash_vld),
    .squash_seq (squash_seq),
    .commit_req (commit_vld),
    .commit_seq (commit_seq),
    .empty      (empty),
    .old_seq    (old_data[SEQ_LO +: SEQW]),
    .young_seq  (young_data[SEQ_LO +: SEQW]),
    .pop_old    (pop_old),
    .pop_young  (pop_young),
    .busy       (busy),
    .undoing    (undoing)
  );

  rhb_release #(.ARCHW(ARCHW), .PREGW(PREGW), .MISC_BASE(MISC_BASE)) u_rel (
    .clk         (clk),
    .rst_n       (rst_n),
    .pop_young   (pop_young),
    .young_arch  (young_data[ARCH_LO +: ARCHW]),
    .young_new   (young_data[NEW_LO +: PREGW]),
    .young_prev  (young_data[0 +: PREGW]),
    .pop_old     (pop_old),
    .old_prev    (old_data[0 +: PREGW]),
    .map_wr_vld  (map_wr_vld),
    .map_wr_arch (map_wr_arch),
    .map_wr_preg (map_wr_preg),
    .free_vld    (free_vld),
    .free_preg   (free_preg),
    .ready_vld   (ready_vld),
    .ready_preg  (ready_preg)
  );

  AST_REQ_CYCLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) squash_vld |-> !free_vld); // R7
  AST_FULL_NOT_EMPTY:  assert property (@(posedge clk) disable iff (!rst_n) !(full && empty)); // R2
  AST_IDLE_SILENT:     assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !free_vld); // R8
endmodule

// File: tb/rename_hist_buf_tb.sv
module rename_hist_buf_tb;
  localparam int DEPTH = 8;
  localparam int SEQW  = 8;
  localparam int ARCHW = 5;
  localparam int PREGW = 6;
  localparam int MISC  = 48;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             push_vld = 1'b0, squash_vld = 1'b0, commit_vld = 1'b0;
  logic [SEQW-1:0]  push_seq = '0, squash_seq = '0, commit_seq = '0;
  logic [ARCHW-1:0] push_arch = '0;
  logic [PREGW-1:0] push_new = '0, push_prev = '0;
  logic             full, empty, busy, map_wr_vld, free_vld, ready_vld;
  logic [ARCHW-1:0] map_wr_arch;
  logic [PREGW-1:0] map_wr_preg, free_preg, ready_preg;

  always #4 clk = ~clk;

  rename_hist_buf u_dut (
    .clk(clk), .rst_n(rst_n),
    .push_vld(push_vld), .push_seq(push_seq), .push_arch(push_arch),
    .push_new(push_new), .push_prev(push_prev),
    .squash_vld(squash_vld), .squash_seq(squash_seq),
    .commit_vld(commit_vld), .commit_seq(commit_seq),
    .full(full), .empty(empty), .busy(busy),
    .map_wr_vld(map_wr_vld), .map_wr_arch(map_wr_arch), .map_wr_preg(map_wr_preg),
    .free_vld(free_vld), .free_preg(free_preg),
    .ready_vld(ready_vld), .ready_preg(ready_preg)
  );

  int total = 0;
  int bad   = 0;

  // Strobe trace recorded away from the clock edge.
  int   ev_n = 0, busy_cyc = 0, stray = 0;
  int   ev_free [64];
  bit   ev_map  [64];
  int   ev_arch [64];
  int   ev_mapp [64];
  bit   ev_rdy  [64];
  int   ev_rdyp [64];

  always begin
    @(negedge clk);
    #2;
    if (busy) busy_cyc++;
    if (free_vld) begin
      if (ev_n < 64) begin
        ev_free[ev_n] = int'(free_preg);
        ev_map[ev_n]  = map_wr_vld;
        ev_arch[ev_n] = int'(map_wr_arch);
        ev_mapp[ev_n] = int'(map_wr_preg);
        ev_rdy[ev_n]  = ready_vld;
        ev_rdyp[ev_n] = int'(ready_preg);
      end
      ev_n++;
    end else if (map_wr_vld || ready_vld) begin
      stray++;
    end
  end

  function automatic int f_arch(int k); return (3 * k + 1) % 32; endfunction
  function automatic int f_new(int k);  return (k % 2 == 1) ? MISC + k : 10 + k; endfunction
  function automatic int f_prev(int k); return 30 + k; endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clr();
    ev_n = 0; busy_cyc = 0; stray = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; push_vld = 0; squash_vld = 0; commit_vld = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic push_one(int k);
    push_vld = 1; push_seq = SEQW'(k); push_arch = ARCHW'(f_arch(k));
    push_new = PREGW'(f_new(k)); push_prev = PREGW'(f_prev(k));
    @(negedge clk);
    push_vld = 0;
  endtask

  task automatic fill(int n);
    for (int k = 1; k <= n; k++) push_one(k);
  endtask

  task automatic wait_idle();
    int g = 0;
    #3;
    while (busy && g < 100) begin
      @(negedge clk); #3; g++;
    end
    @(negedge clk);
  endtask

  task automatic squash(int s);
    squash_vld = 1; squash_seq = SEQW'(s);
    @(negedge clk);
    squash_vld = 0;
    wait_idle();
  endtask

  task automatic commit(int c);
    commit_vld = 1; commit_seq = SEQW'(c);
    @(negedge clk);
    commit_vld = 0;
    wait_idle();
  endtask

  // Undo trace for entries k = hi down to lo, starting at trace index base.
  task automatic check_undo_at(int base, int hi, int lo, string req);
    for (int k = hi; k >= lo; k--) begin
      int i = base + hi - k;
      bit misc = (f_new(k) >= MISC);
      bit ok = (ev_free[i] == f_new(k)) && ev_map[i] && (ev_arch[i] == f_arch(k)) &&
               (ev_mapp[i] == f_prev(k)) && (ev_rdy[i] == misc) && (!misc || ev_rdyp[i] == f_new(k));
      chk(ok, req, $sformatf("undo entry %0d free reg", k), ev_free[i], f_new(k));
    end
  endtask

  task automatic check_retire_at(int base, int lo, int hi, string req);
    for (int k = lo; k <= hi; k++) begin
      int i = base + k - lo;
      bit ok = (ev_free[i] == f_prev(k)) && !ev_map[i] && !ev_rdy[i];
      chk(ok, req, $sformatf("retire entry %0d free reg", k), ev_free[i], f_prev(k));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 reset state
    @(negedge clk);
    #1;
    chk(empty && !full && !busy && !map_wr_vld && !free_vld && !ready_vld, "R1", "reset outputs",
        {empty, full, busy, free_vld}, 4'b1000);
    do_reset();
    chk(empty && !full && !busy && !free_vld, "R1", "after release", {empty, full, busy, free_vld}, 4'b1000);

    // R3 R4 R8 R9 R5: squash sweep over fill level and bound, then drain by commit
    for (int n = 0; n <= DEPTH; n++) begin
      for (int s = 0; s <= n; s++) begin
        int rem, keep;
        do_reset();
        fill(n);
        chk(full == (n == DEPTH) && empty == (n == 0), "R2", $sformatf("flags n=%0d", n),
            {full, empty}, {(n == DEPTH), (n == 0)});
        clr();
        squash(s);
        rem = n - s;
        chk(ev_n == rem && stray == 0, (n == 0) ? "R9" : "R3", $sformatf("undo count n=%0d s=%0d", n, s), ev_n, rem);
        chk(busy_cyc == rem + 1, "R8", $sformatf("undo busy n=%0d s=%0d", n, s), busy_cyc, rem + 1);
        check_undo_at(0, n, s + 1, "R4");
        keep = s;
        clr();
        commit(255);
        chk(ev_n == keep && stray == 0, "R5", $sformatf("drain count n=%0d s=%0d", n, s), ev_n, keep);
        check_retire_at(0, 1, keep, "R5");
      end
    end

    // R5 R6 R8: partial commit sweep
    for (int n = 0; n <= DEPTH; n++) begin
      for (int c = 0; c <= n; c++) begin
        do_reset();
        fill(n);
        clr();
        commit(c);
        chk(ev_n == c && stray == 0, (c == 0) ? "R6" : "R5", $sformatf("retire count n=%0d c=%0d", n, c), ev_n, c);
        chk(busy_cyc == c + 1, "R8", $sformatf("retire busy n=%0d c=%0d", n, c), busy_cyc, c + 1);
        check_retire_at(0, 1, c, "R5");
      end
    end

    // R2: push while full is dropped
    do_reset();
    fill(DEPTH);
    push_one(DEPTH + 1);
    chk(full, "R2", "still full", full, 1);
    clr();
    commit(255);
    chk(ev_n == DEPTH, "R2", "drain after overfill", ev_n, DEPTH);
    check_retire_at(0, 1, DEPTH, "R2");

    // R7: squash and commit in the same cycle
    do_reset();
    fill(4);
    clr();
    squash_vld = 1; squash_seq = 2; commit_vld = 1; commit_seq = 255;
    @(negedge clk);
    squash_vld = 0; commit_vld = 0;
    wait_idle();
    chk(ev_n == 2, "R7", "same-cycle commit dropped", ev_n, 2);
    check_undo_at(0, 4, 3, "R7");
    clr();
    commit(255);
    chk(ev_n == 2, "R7", "remaining after collision", ev_n, 2);

    // R7: squash stops a commit walk; commit during squash walk dropped
    do_reset();
    fill(6);
    clr();
    commit_vld = 1; commit_seq = 255;
    @(negedge clk);
    commit_vld = 0;
    @(negedge clk);
    squash_vld = 1; squash_seq = 3; commit_vld = 1;
    @(negedge clk);
    squash_vld = 0;
    @(negedge clk);
    commit_vld = 0;
    wait_idle();
    chk(ev_n == 4 && stray == 0, "R7", "abort trace length", ev_n, 4);
    check_retire_at(0, 1, 1, "R7");
    check_undo_at(1, 6, 4, "R7");
    clr();
    commit(255);
    chk(ev_n == 2, "R7", "entries left after abort", ev_n, 2);
    check_retire_at(0, 2, 3, "R7");

    // R10: pushes dropped around a squash
    do_reset();
    fill(4);
    clr();
    squash_vld = 1; squash_seq = 2; push_vld = 1; push_seq = 9;
    push_arch = ARCHW'(f_arch(9)); push_new = PREGW'(f_new(9)); push_prev = PREGW'(f_prev(9));
    @(negedge clk);
    squash_vld = 0;
    @(negedge clk);
    @(negedge clk);
    push_vld = 0;
    wait_idle();
    chk(ev_n == 2, "R10", "undo with pushes held", ev_n, 2);
    clr();
    commit(255);
    chk(ev_n == 2, "R10", "no push landed during squash", ev_n, 2);
    check_retire_at(0, 1, 2, "R10");

    // R10: push during a commit walk lands
    do_reset();
    fill(3);
    clr();
    commit_vld = 1; commit_seq = 2;
    @(negedge clk);
    commit_vld = 0;
    push_one(4);
    wait_idle();
    chk(ev_n == 2, "R10", "commit with push", ev_n, 2);
    clr();
    commit(255);
    chk(ev_n == 2, "R10", "push during commit kept", ev_n, 2);
    check_retire_at(0, 3, 4, "R10");

    // R11: later commit replaces the bound
    do_reset();
    fill(6);
    clr();
    commit_vld = 1; commit_seq = 1;
    @(negedge clk);
    commit_seq = 4;
    @(negedge clk);
    commit_vld = 0;
    wait_idle();
    chk(ev_n == 4, "R11", "retire count with new bound", ev_n, 4);
    chk(busy_cyc == 5, "R11", "busy with new bound", busy_cyc, 5);
    check_retire_at(0, 1, 4, "R11");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule